// File: doc/BRIEF.md
# Fixed-Latency Trigger Word Link

This block carries trigger decisions made every 4 ns over a distribution link that moves one 16-bit word every 16 ns, and rebuilds them at the far end as a 3-bit stream at the original rate. Each 4 ns tick carries trigger 1, trigger 2 and sync. The sending half gathers four consecutive ticks into one framed word. It merges an asynchronous user trigger, such as a pulser or calibration source, into trigger 1. While any crate reports busy or error, it forces the trigger bits low.

The receiving half unpacks each word one tick per cycle, with the oldest tick first. The delay from a tick entering the sender to that tick leaving the receiver is the same for every tick and every crate. Each word carries a sequence count and even parity, and the receiver reports any word that breaks either rule. Both halves run on the 250 MHz clock. The 62.5 MHz word rate appears as a one-cycle strobe every fourth cycle. The fibre between the halves lies outside the block: the word and strobe leave on the tx ports and come back on the rx ports.

Top module: `tw_trig_link`

## Requirements
- R1: While reset is held and in the first cycle after it, `tx_word_o`, `tx_strobe_o`, `fe_bits_o` and `rx_err_o` are all zero.
- R2: A sent word has this layout. Bits 11:0 hold four 3-bit tick slots, with the oldest tick in bits 2:0. Within a slot, bit 0 is trigger 1, bit 1 is trigger 2 and bit 2 is sync. Bits 13:12 hold a sequence count that starts at 0 after reset and rises by 1 per word. Bit 14 is the OR of bits 11:0. Bit 15 makes the XOR of all 16 bits zero. `tx_strobe_o` is high for exactly the one cycle in which a new word is presented.
- R3: After reset, every four consecutive ticks form one word. A tick with sync set always starts a new word in slot 0. Any ticks already gathered for an unfinished word are discarded, and that word is never sent.
- R4: With the tx ports looped directly to the rx ports, each tick sampled at a clock edge appears on `fe_bits_o` after exactly the fourth following edge. In cycles that carry no delivered tick, `fe_bits_o` is zero.
- R5: While any bit of `busy_i` or `fault_i` is high during a tick, trigger 1 and trigger 2 of that tick are sent as zero, and its sync bit passes unchanged.
- R6: A rising level on `user_trig_i`, first seen at edge m, adds trigger 1 to the tick sampled at edge m+2. A level held high yields only that one pulse. The added pulse is also subject to R5.
- R7: A received word whose 16 bits XOR to one is dropped, and its four ticks come out as zero. `rx_err_o` pulses for one cycle, in the cycle where that word's first tick would have appeared.
- R8: A received word with good parity but a sequence count other than the previous accepted count plus one raises a one-cycle `rx_err_o` pulse, in the cycle of its first tick. Its ticks are still delivered.
- R9: The receiver does not check the sequence count of the first word after reset, nor of the first word after any R7 or R8 error. After an error, therefore, the next word that is intact raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 250 MHz tick clock, shared by both halves |
| rst | input | 1 | Synchronous active-high reset |
| trig1_i | input | 1 | Trigger 1 decision for the current tick |
| trig2_i | input | 1 | Trigger 2 decision for the current tick |
| sync_i | input | 1 | Sync for the current tick; restarts the word phase |
| user_trig_i | input | 1 | Asynchronous user trigger level, merged into trigger 1 |
| busy_i | input | N_CRATES | Busy status returned by each crate |
| fault_i | input | N_CRATES | Error status returned by each crate |
| tx_word_o | output | 16 | Framed word toward the link |
| tx_strobe_o | output | 1 | High in the cycle a new tx word is presented |
| rx_word_i | input | 16 | Framed word arriving from the link |
| rx_strobe_i | input | 1 | High in the cycle a new rx word is presented |
| fe_bits_o | output | 3 | Restored tick: bit 0 trigger 1, bit 1 trigger 2, bit 2 sync |
| rx_err_o | output | 1 | One-cycle pulse on a parity or sequence fault |

## Verification
The assertions check several properties on every cycle. Every sent word has even parity. Word strobes are at least four cycles apart. The user-trigger edge pulse lasts a single cycle. An intact received word puts its first slot out on the next cycle, and a word with bad parity yields a zero output and an error. The exact four-cycle latency across the loop, the way sync discards a partial word, busy gating with sync still passing, and the one-shot recovery of the sequence check after a fault can only be seen in the bench's scenarios. There, a scoreboard predicts every output cycle and every sent word.

// File: rtl/tw_pkg.sv
package tw_pkg;

    localparam int TICK_W = 3;
    localparam int SLOTS  = 4;
    localparam int SEQ_W  = 2;
    localparam int PH_W   = $clog2(SLOTS);
    localparam int WORD_W = SLOTS * TICK_W + SEQ_W + 2;

    typedef struct packed {
        logic sync;
        logic trig2;
        logic trig1;
    } tick_t;

    typedef struct packed {
        logic                   parity;
        logic                   active;
        logic [SEQ_W-1:0]       seq;
        tick_t [SLOTS-1:0]      slot;
    } word_t;

    function automatic word_t frame_word(tick_t [SLOTS-1:0] s, logic [SEQ_W-1:0] q);
        word_t w;
        w.slot   = s;
        w.seq    = q;
        w.active = |s;
        w.parity = 1'b0;
        w.parity = ^w;
        return w;
    endfunction

    function automatic logic parity_good(word_t w);
        return ~(^w);
    endfunction

endpackage

// File: rtl/tw_async_edge.sv
module tw_async_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] chain;
    logic              held;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            held  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], async_i};
            held  <= chain[STAGES-1];
        end
    end

    assign rise_o = chain[STAGES-1] & ~held;

    // R6: a held level gives a single-cycle pulse
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

endmodule

// File: rtl/tw_sender.sv
module tw_sender
    import tw_pkg::*;
#(
    parameter int N_CRATES = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  tick_t               tick_i,
    input  logic                user_rise_i,
    input  logic [N_CRATES-1:0] busy_i,
    input  logic [N_CRATES-1:0] fault_i,
    output word_t               word_o,
    output logic                strobe_o
);
    logic [PH_W-1:0]   phase;
    logic [PH_W-1:0]   slot_idx;
    tick_t [SLOTS-1:0] gather;
    tick_t [SLOTS-1:0] gather_nxt;
    logic [SEQ_W-1:0]  seq;
    tick_t             gated;
    logic              inhibit;
    logic              closing;

    assign inhibit = (|busy_i) | (|fault_i);

    always_comb begin
        gated.trig1 = (tick_i.trig1 | user_rise_i) & ~inhibit;
        gated.trig2 = tick_i.trig2 & ~inhibit;
        gated.sync  = tick_i.sync;
    end

    always_comb begin
        slot_idx   = gated.sync ? '0 : phase;
        gather_nxt = gated.sync ? '0 : gather;
        gather_nxt[slot_idx] = gated;
        closing    = (slot_idx == PH_W'(SLOTS - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= '0;
            gather   <= '0;
            seq      <= '0;
            word_o   <= '0;
            strobe_o <= 1'b0;
        end else begin
            phase    <= slot_idx + 1'b1;
            gather   <= gather_nxt;
            strobe_o <= closing;
            if (closing) begin
                word_o <= frame_word(gather_nxt, seq);
                seq    <= seq + 1'b1;
            end
        end
    end

    // R2: every presented word carries even parity
    a_r2_tx_parity: assert property (@(posedge clk) disable iff (rst)
        strobe_o |-> parity_good(word_o));

    // R3: words are never closer than four ticks apart
    a_r3_word_gap: assert property (@(posedge clk) disable iff (rst)
        strobe_o |=> !strobe_o ##1 !strobe_o ##1 !strobe_o);

endmodule

// File: rtl/tw_receiver.sv
module tw_receiver
    import tw_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  word_t word_i,
    input  logic  strobe_i,
    output tick_t tick_o,
    output logic  err_o
);
    tick_t [SLOTS-2:0] pending;
    logic [PH_W-1:0]   rphase;
    logic [SEQ_W-1:0]  seq_exp;
    logic              seq_armed;
    logic              par_bad;
    logic              seq_bad;

    assign par_bad = strobe_i & ~parity_good(word_i);
    assign seq_bad = strobe_i & ~par_bad & seq_armed & (word_i.seq != seq_exp);

    always_ff @(posedge clk) begin
        if (rst) begin
            pending   <= '0;
            rphase    <= PH_W'(SLOTS - 1);
            seq_exp   <= '0;
            seq_armed <= 1'b0;
            tick_o    <= '0;
            err_o     <= 1'b0;
        end else begin
            err_o <= par_bad | seq_bad;
            if (strobe_i) begin
                rphase <= '0;
                if (par_bad) begin
                    tick_o    <= '0;
                    pending   <= '0;
                    seq_armed <= 1'b0;
                end else begin
                    tick_o    <= word_i.slot[0];
                    pending   <= word_i.slot[SLOTS-1:1];
                    seq_armed <= ~seq_bad;
                    seq_exp   <= word_i.seq + 1'b1;
                end
            end else if (rphase == PH_W'(SLOTS - 1)) begin
                tick_o <= '0;
            end else begin
                rphase  <= rphase + 1'b1;
                tick_o  <= pending[0];
                pending <= {tick_t'('0), pending[SLOTS-2:1]};
            end
        end
    end

    // R4: an intact word puts its oldest slot out on the next cycle
    a_r4_first_slot: assert property (@(posedge clk) disable iff (rst)
        (strobe_i && parity_good(word_i)) |=> (tick_o == $past(word_i.slot[0])));

    // R7: a word with bad parity is dropped and flagged
    a_r7_drop_bad: assert property (@(posedge clk) disable iff (rst)
        (strobe_i && !parity_good(word_i)) |=> (tick_o == '0 && err_o));

endmodule

// File: rtl/tw_trig_link.sv
module tw_trig_link
    import tw_pkg::*;
#(
    parameter int N_CRATES    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                trig1_i,
    input  logic                trig2_i,
    input  logic                sync_i,
    input  logic                user_trig_i,
    input  logic [N_CRATES-1:0] busy_i,
    input  logic [N_CRATES-1:0] fault_i,
    output logic [WORD_W-1:0]   tx_word_o,
    output logic                tx_strobe_o,
    input  logic [WORD_W-1:0]   rx_word_i,
    input  logic                rx_strobe_i,
    output logic [TICK_W-1:0]   fe_bits_o,
    output logic                rx_err_o
);
    tick_t in_tick;
    tick_t out_tick;
    word_t tx_w;
    word_t rx_w;
    logic  user_rise;

    assign in_tick.trig1 = trig1_i;
    assign in_tick.trig2 = trig2_i;
    assign in_tick.sync  = sync_i;

    tw_async_edge #(.STAGES(SYNC_STAGES)) u_user (
        .clk     (clk),
        .rst     (rst),
        .async_i (user_trig_i),
        .rise_o  (user_rise)
    );

    tw_sender #(.N_CRATES(N_CRATES)) u_tx (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (in_tick),
        .user_rise_i (user_rise),
        .busy_i      (busy_i),
        .fault_i     (fault_i),
        .word_o      (tx_w),
        .strobe_o    (tx_strobe_o)
    );

    assign tx_word_o = tx_w;
    assign rx_w      = rx_word_i;

    tw_receiver u_rx (
        .clk      (clk),
        .rst      (rst),
        .word_i   (rx_w),
        .strobe_i (rx_strobe_i),
        .tick_o   (out_tick),
        .err_o    (rx_err_o)
    );

    assign fe_bits_o = out_tick;

endmodule

// File: tb/tw_trig_link_bench.sv
module tw_trig_link_bench;
    localparam int NC = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          trig1 = 0, trig2 = 0, sync = 0, usr = 0;
    logic [NC-1:0] busy = '0, fault = '0;
    logic [15:0]   tx_word, rx_word;
    logic          tx_strobe;
    logic [2:0]    fe_bits;
    logic          rx_err;
    logic [15:0]   corrupt_mask = '0;
    int            mask_hold = 0;

    always #2 clk = ~clk;

    assign rx_word = tx_word ^ (tx_strobe ? corrupt_mask : 16'h0000);

    tw_trig_link #(.N_CRATES(NC)) u_tw_trig_link (
        .clk(clk), .rst(rst), .trig1_i(trig1), .trig2_i(trig2), .sync_i(sync),
        .user_trig_i(usr), .busy_i(busy), .fault_i(fault),
        .tx_word_o(tx_word), .tx_strobe_o(tx_strobe),
        .rx_word_i(rx_word), .rx_strobe_i(tx_strobe),
        .fe_bits_o(fe_bits), .rx_err_o(rx_err)
    );

    int compared = 0, mismatched = 0;
    int ecnt = 0;
    always @(posedge clk) ecnt <= ecnt + 1;

    int         qdue[$];
    logic [2:0] qv[$];
    logic       qerr[$];
    string      qreq[$];
    int         tdue[$];
    logic [15:0] tword[$];

    int         bph = 0;
    logic [1:0] wseq = 0;
    logic [2:0] wslot [4];
    logic [2:0] uh = '0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input logic t1, input logic t2, input logic sy, input logic u,
                        input logic [NC-1:0] bz, input logic [NC-1:0] fl,
                        input logic cpar, input logic cseq, input string req);
        logic inh, uterm;
        logic [2:0] e;
        logic [15:0] w;
        int n;
        trig1 = t1; trig2 = t2; sync = sy; usr = u; busy = bz; fault = fl;
        if (mask_hold > 0) begin
            mask_hold--;
            if (mask_hold == 0) corrupt_mask = '0;
        end
        inh   = (|bz) | (|fl);
        uterm = uh[1] & ~uh[2];
        uh    = {uh[1], uh[0], u};
        e     = {sy, t2 & ~inh, (t1 | uterm) & ~inh};
        if (sy && bph != 0) begin
            for (int i = 0; i < bph; i++) qv[qv.size() - 1 - i] = 3'b000;
            bph = 0;
        end
        qdue.push_back(ecnt + 5); qv.push_back(e); qerr.push_back(1'b0); qreq.push_back(req);
        wslot[bph] = e;
        if (bph == 3) begin
            w[11:0]  = {wslot[3], wslot[2], wslot[1], wslot[0]};
            w[13:12] = wseq;
            w[14]    = |w[11:0];
            w[15]    = ^w[14:0];
            tdue.push_back(ecnt + 1); tword.push_back(w);
            wseq++;
            n = qv.size();
            if (cpar) begin
                corrupt_mask = 16'h0004; mask_hold = 2;
                for (int i = 0; i < 4; i++) qv[n - 1 - i] = 3'b000;
                qerr[n - 4] = 1'b1;
            end else if (cseq) begin
                corrupt_mask = 16'hA000; mask_hold = 2;
                qerr[n - 4] = 1'b1;
            end
            bph = 0;
        end else begin
            bph++;
        end
        @(negedge clk);
    endtask

    task automatic idle(input int k, input string req);
        for (int i = 0; i < k; i++) tick(0, 0, 0, usr, '0, '0, 0, 0, req);
    endtask

    // Scoreboard monitor: compares every delivered cycle and every sent word
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                while (qdue.size() > 0 && qdue[0] <= ecnt) begin
                    check({qreq[0], " fe/err"}, {28'd0, rx_err, fe_bits}, {28'd0, qerr[0], qv[0]});
                    void'(qdue.pop_front()); void'(qv.pop_front());
                    void'(qerr.pop_front()); void'(qreq.pop_front());
                end
                if (tx_strobe) begin
                    if (tdue.size() == 0 || tdue[0] != ecnt) begin
                        check("R3 unexpected word strobe", 32'd1, 32'd0);
                    end else begin
                        check("R2 word layout", {16'd0, tx_word}, {16'd0, tword[0]});
                        void'(tdue.pop_front()); void'(tword.pop_front());
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL R4 watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 tx word", {16'd0, tx_word}, 32'd0);
        check("R1 tx strobe", {31'd0, tx_strobe}, 32'd0);
        check("R1 fe bits", {29'd0, fe_bits}, 32'd0);
        check("R1 rx err", {31'd0, rx_err}, 32'd0);
        rst = 1'b0;

        // R2 / R4: mixed trigger patterns, sync only on word boundaries
        for (int k = 0; k < 48; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            tick(lfsr[0], lfsr[3] & lfsr[5], (bph == 0) && lfsr[7] && lfsr[9], 0, '0, '0, 0, 0, "R4");
        end
        idle(4, "R4");

        // R5: busy from one crate, fault from another, sync still passes
        for (int k = 0; k < 8; k++) tick(1, 1, (bph == 0), 0, 4'b0100, '0, 0, 0, "R5");
        for (int k = 0; k < 4; k++) tick(1, k[0], 0, 0, '0, 4'b0001, 0, 0, "R5");
        tick(1, 1, 0, 0, '0, '0, 0, 0, "R5");

        // R6: user trigger held high gives one pulse; a rise during busy is dropped
        for (int k = 0; k < 8; k++) tick(0, 0, 0, 1, '0, '0, 0, 0, "R6");
        for (int k = 0; k < 4; k++) tick(0, 0, 0, 0, '0, '0, 0, 0, "R6");
        for (int k = 0; k < 6; k++) tick(0, 0, 0, 1, 4'b1000, '0, 0, 0, "R6");
        tick(0, 0, 0, 0, '0, '0, 0, 0, "R6");
        idle(4, "R6");

        // R3: sync in the middle of a word discards the partial word
        while (bph != 2) tick(1, 0, 0, 0, '0, '0, 0, 0, "R3");
        tick(0, 1, 1, 0, '0, '0, 0, 0, "R3");
        for (int k = 0; k < 7; k++) tick(k[0], 1, 0, 0, '0, '0, 0, 0, "R3");
        while (bph != 3) tick(0, 1, 0, 0, '0, '0, 0, 0, "R3");
        tick(1, 0, 1, 0, '0, '0, 0, 0, "R3");
        idle(8, "R3");

        // R7: parity fault drops a word carrying triggers
        while (bph != 0) tick(0, 0, 0, 0, '0, '0, 0, 0, "R7");
        for (int k = 0; k < 3; k++) tick(1, 0, 0, 0, '0, '0, 0, 0, "R7");
        tick(1, 1, 0, 0, '0, '0, 1, 0, "R7");
        // R9: next intact word is not sequence-checked
        for (int k = 0; k < 8; k++) tick(k[1], 0, 0, 0, '0, '0, 0, 0, "R9");

        // R8: sequence fault, ticks still delivered
        for (int k = 0; k < 3; k++) tick(0, 1, 0, 0, '0, '0, 0, 0, "R8");
        tick(1, 0, 0, 0, '0, '0, 0, 1, "R8");
        // R9: recovery after the sequence fault raises no further error
        for (int k = 0; k < 12; k++) tick(k[0], k[2], 0, 0, '0, '0, 0, 0, "R9");
        idle(8, "R4");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule